// File: doc/BRIEF.md
# Banked Register and Data Memory Mapper

This block sits between a small core's operand path and its storage. The core issues short 6-bit direct register addresses. The mapper turns each request into a physical target and a physical address, one cycle later. The low sixteen direct addresses form a window onto special-function registers. That window is paged by a page-select register. Pages are populated unevenly, and every slot that has no register behind it is reserved. The top thirty-two direct addresses form a window onto one 32-byte block of a 128-byte general-purpose RAM. A block-select register chooses that block.

General-purpose RAM can also be reached indirectly. An 8-bit pointer register gives both the block and the byte, so the current block selection has no effect on it. The 4 KB data RAM is never addressed directly. The core loads a 16-bit pointer a byte at a time and then goes through a data-port address. The pointer advances by one after every data-port access. Pointer values beyond the RAM are flagged and produce no write.

The select and pointer registers live in the block, and the core reads them back at fixed local addresses. The peripheral registers and the RAM arrays themselves sit outside the block.

The output stage is a two-state machine. In ST_IDLE no result is presented. In ST_RESP a decoded result is presented. The transition "issue" (ST_IDLE to ST_RESP) and the transition "stream" (ST_RESP to ST_RESP) happen on any cycle that has a request. The transition "drain" (ST_RESP to ST_IDLE) and the transition "rest" (ST_IDLE to ST_IDLE) happen on any cycle without one.

Top module: `mem_bank_mapper`

## Requirements
- R1: After reset, the page select, block select, indirect pointer and data pointer are all zero, and no result is presented.
- R2: A direct address 0x00-0x0F whose page select p is at most 5 and whose offset is below the fill of page p maps to target code 1 with address p*16+offset. The default fills are 16, 12, 8, 10, 4 and 6 for pages 0 to 5. The write flag follows the request.
- R3: In the 0x00-0x0F window, an offset at or above the page fill, or a page select above 5, gives target code 5 and raises `out_reserved`. It reads 0x00 and its write is dropped (`out_write` low).
- R4: A direct address 0x20-0x3F maps to target code 2 with address bsel*32+(addr-0x20). Here bsel is bits [1:0] of the last value written to 0x11.
- R5: An access to 0x13 maps to target code 2 with address iptr[6:0]. Bits [6:5] of iptr give the block and bits [4:0] give the byte, whatever bsel holds. iptr is written at 0x12.
- R6: Local registers give target code 4, never raise `out_write`, and on a read return their contents on `out_rdata`. The registers are: page select at 0x10 (8 bits as written), block select at 0x11 (zero-extended), iptr at 0x12, data pointer low byte at 0x14 and high byte at 0x15.
- R7: An access to 0x16 while the data pointer is below 4096 gives target code 3 with address ptr[11:0]. The pointer is then one higher, wrapping from 0xFFFF to 0x0000.
- R8: An access to 0x16 while the data pointer is 4096 or more gives target code 5 with `out_oor` and `out_reserved` high and `out_write` low. The pointer still advances.
- R9: Direct addresses 0x17-0x1F give target code 5. They read 0x00 and ignore writes.
- R10: Each request's result is presented, with `out_valid` high, in the cycle after the request. A cycle without a request presents `out_valid` low and target code 0.
- R11: A write to a select or pointer register governs every request issued in the following cycle and after, including a back-to-back one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | Request is a write |
| req_addr | input | 6 | Direct register address |
| req_wdata | input | 8 | Write data |
| out_valid | output | 1 | Decoded result present |
| out_target | output | 3 | 0 none, 1 special reg, 2 general RAM, 3 data RAM, 4 local, 5 reserved |
| out_addr | output | 12 | Physical address within the target (0 for local-free reserved) |
| out_write | output | 1 | Write to be performed at the target |
| out_wdata | output | 8 | Write data carried with the result |
| out_rdata | output | 8 | Read data for local and reserved targets |
| out_reserved | output | 1 | Result hit a reserved location |
| out_oor | output | 1 | Data-port access with pointer beyond the data RAM |

## Verification
The bench builds the mapper with its default parameters: six pages with fills of 16, 12, 8, 10, 4 and 6, four 32-byte blocks, and a 4096-byte data RAM behind a 16-bit pointer. Because the fills are uneven, every page has its own reserved boundary, and page selects 4, 5 and 6 sit next to the last valid page. With a 4096-byte RAM and a 16-bit pointer, both the last in-range byte and the first out-of-range byte can be reached with two pointer writes, and so can the wrap from 0xFFFF to zero. Back-to-back requests show that a select write takes effect for the very next request.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    localparam int DIR_AW = 6;
    localparam int DATA_W = 8;

    localparam logic [DIR_AW-1:0] LOC_PSEL = 6'h10;
    localparam logic [DIR_AW-1:0] LOC_BSEL = 6'h11;
    localparam logic [DIR_AW-1:0] LOC_IPTR = 6'h12;
    localparam logic [DIR_AW-1:0] LOC_IDAT = 6'h13;
    localparam logic [DIR_AW-1:0] LOC_DPL  = 6'h14;
    localparam logic [DIR_AW-1:0] LOC_DPH  = 6'h15;
    localparam logic [DIR_AW-1:0] LOC_DDAT = 6'h16;
    localparam logic [DIR_AW-1:0] GPR_BASE = 6'h20;

    typedef enum logic [2:0] {
        TGT_NONE  = 3'd0,
        TGT_SFR   = 3'd1,
        TGT_GPR   = 3'd2,
        TGT_DRAM  = 3'd3,
        TGT_LOCAL = 3'd4,
        TGT_RSVD  = 3'd5
    } tgt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sfr_page_decode.sv
module sfr_page_decode #(
    parameter int N_PAGES    = 6,
    parameter int PAGE_BYTES = 16,
    parameter logic [N_PAGES*8-1:0] PAGE_FILL = {8'd6, 8'd4, 8'd10, 8'd8, 8'd12, 8'd16},
    parameter int PHYS_W     = 12,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = $clog2(N_PAGES)
) (
    input  logic [7:0]        psel,
    input  logic [OFF_W-1:0]  off,
    output logic              hit,
    output logic [PHYS_W-1:0] phys
);

    logic [N_PAGES-1:0] page_ok;

    for (genvar p = 0; p < N_PAGES; p++) begin : g_page
        assign page_ok[p] = (psel == 8'(p)) &&
                            ({{(8-OFF_W){1'b0}}, off} < PAGE_FILL[p*8 +: 8]);
    end

    assign hit  = |page_ok;
    assign phys = PHYS_W'({psel[PG_W-1:0], off});

endmodule

// File: rtl/gpr_bank_map.sv
module gpr_bank_map #(
    parameter int BLOCKS      = 4,
    parameter int BLOCK_BYTES = 32,
    parameter int PHYS_W      = 12,
    localparam int BS_W       = $clog2(BLOCKS),
    localparam int BO_W       = $clog2(BLOCK_BYTES)
) (
    input  logic                 indirect,
    input  logic [BS_W-1:0]      bsel,
    input  logic [BO_W-1:0]      dir_off,
    input  logic [BS_W+BO_W-1:0] iptr,
    output logic [PHYS_W-1:0]    phys
);

    logic [BS_W+BO_W-1:0] flat;

    always_comb begin
        if (indirect) begin
            flat = iptr;
        end else begin
            flat = {bsel, dir_off};
        end
    end

    assign phys = PHYS_W'(flat);

endmodule

// File: rtl/dram_window.sv
module dram_window #(
    parameter int DRAM_BYTES = 4096,
    parameter int DATA_W     = 8,
    parameter int PHYS_W     = 12,
    localparam int DPTR_W    = 2 * DATA_W,
    localparam int DRAM_AW   = $clog2(DRAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              step,
    input  logic [DATA_W-1:0] wdata,
    output logic [DPTR_W-1:0] ptr,
    output logic              in_range,
    output logic [PHYS_W-1:0] phys
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_lo) begin
            ptr[DATA_W-1:0] <= wdata;
        end else if (wr_hi) begin
            ptr[DPTR_W-1:DATA_W] <= wdata;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

    assign in_range = (ptr < DPTR_W'(DRAM_BYTES));
    assign phys     = PHYS_W'(ptr[DRAM_AW-1:0]);

endmodule

// File: rtl/mem_bank_mapper.sv
module mem_bank_mapper
    import mbm_pkg::*;
#(
    parameter int N_PAGES     = 6,
    parameter int PAGE_BYTES  = 16,
    parameter logic [N_PAGES*8-1:0] PAGE_FILL = {8'd6, 8'd4, 8'd10, 8'd8, 8'd12, 8'd16},
    parameter int GPR_BLOCKS  = 4,
    parameter int BLOCK_BYTES = 32,
    parameter int DRAM_BYTES  = 4096,
    localparam int PHYS_W     = imax($clog2(DRAM_BYTES),
                                     imax($clog2(N_PAGES) + $clog2(PAGE_BYTES),
                                          $clog2(GPR_BLOCKS) + $clog2(BLOCK_BYTES))),
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int BS_W       = $clog2(GPR_BLOCKS),
    localparam int BO_W       = $clog2(BLOCK_BYTES),
    localparam int DPTR_W     = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DIR_AW-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              out_valid,
    output logic [2:0]        out_target,
    output logic [PHYS_W-1:0] out_addr,
    output logic              out_write,
    output logic [DATA_W-1:0] out_wdata,
    output logic [DATA_W-1:0] out_rdata,
    output logic              out_reserved,
    output logic              out_oor
);

    rsp_state_e state, state_nx;

    logic [7:0]        psel;
    logic [BS_W-1:0]   bsel;
    logic [7:0]        iptr;
    logic [DPTR_W-1:0] dptr;

    logic              sfr_hit;
    logic [PHYS_W-1:0] sfr_phys;
    logic [PHYS_W-1:0] gpr_phys;
    logic [PHYS_W-1:0] dram_phys;
    logic              dram_ok;
    logic              gpr_ind;

    logic              wr_any;
    logic              wr_psel, wr_bsel, wr_iptr, wr_dpl, wr_dph;
    logic              port_step;

    tgt_e              nx_tgt;
    logic [PHYS_W-1:0] nx_addr;
    logic [DATA_W-1:0] nx_rdata;
    logic              nx_wr;
    logic              nx_oor;

    // ---------------------------------------------------------------
    // Sub-decoders
    // ---------------------------------------------------------------
    sfr_page_decode #(
        .N_PAGES    (N_PAGES),
        .PAGE_BYTES (PAGE_BYTES),
        .PAGE_FILL  (PAGE_FILL),
        .PHYS_W     (PHYS_W)
    ) u_sfr (
        .psel (psel),
        .off  (req_addr[OFF_W-1:0]),
        .hit  (sfr_hit),
        .phys (sfr_phys)
    );

    assign gpr_ind = (req_addr == LOC_IDAT);

    gpr_bank_map #(
        .BLOCKS      (GPR_BLOCKS),
        .BLOCK_BYTES (BLOCK_BYTES),
        .PHYS_W      (PHYS_W)
    ) u_gpr (
        .indirect (gpr_ind),
        .bsel     (bsel),
        .dir_off  (req_addr[BO_W-1:0]),
        .iptr     (iptr[BS_W+BO_W-1:0]),
        .phys     (gpr_phys)
    );

    assign wr_any    = req_valid && req_write;
    assign wr_psel   = wr_any && (req_addr == LOC_PSEL);
    assign wr_bsel   = wr_any && (req_addr == LOC_BSEL);
    assign wr_iptr   = wr_any && (req_addr == LOC_IPTR);
    assign wr_dpl    = wr_any && (req_addr == LOC_DPL);
    assign wr_dph    = wr_any && (req_addr == LOC_DPH);
    assign port_step = req_valid && (req_addr == LOC_DDAT);

    dram_window #(
        .DRAM_BYTES (DRAM_BYTES),
        .DATA_W     (DATA_W),
        .PHYS_W     (PHYS_W)
    ) u_dwin (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo    (wr_dpl),
        .wr_hi    (wr_dph),
        .step     (port_step),
        .wdata    (req_wdata),
        .ptr      (dptr),
        .in_range (dram_ok),
        .phys     (dram_phys)
    );

    // ---------------------------------------------------------------
    // Select registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psel <= '0;
            bsel <= '0;
            iptr <= '0;
        end else begin
            if (wr_psel) psel <= req_wdata;
            if (wr_bsel) bsel <= req_wdata[BS_W-1:0];
            if (wr_iptr) iptr <= req_wdata;
        end
    end

    // ---------------------------------------------------------------
    // Address decode
    // ---------------------------------------------------------------
    always_comb begin
        nx_tgt   = TGT_NONE;
        nx_addr  = '0;
        nx_rdata = '0;
        nx_wr    = 1'b0;
        nx_oor   = 1'b0;
        if (req_addr < DIR_AW'(PAGE_BYTES)) begin
            if (sfr_hit) begin
                nx_tgt  = TGT_SFR;
                nx_addr = sfr_phys;
                nx_wr   = req_write;
            end else begin
                nx_tgt  = TGT_RSVD;
            end
        end else if (req_addr >= GPR_BASE) begin
            nx_tgt  = TGT_GPR;
            nx_addr = gpr_phys;
            nx_wr   = req_write;
        end else begin
            unique case (req_addr)
                LOC_PSEL: begin
                    nx_tgt   = TGT_LOCAL;
                    nx_addr  = PHYS_W'(req_addr);
                    nx_rdata = req_write ? '0 : psel;
                end
                LOC_BSEL: begin
                    nx_tgt   = TGT_LOCAL;
                    nx_addr  = PHYS_W'(req_addr);
                    nx_rdata = req_write ? '0 : DATA_W'(bsel);
                end
                LOC_IPTR: begin
                    nx_tgt   = TGT_LOCAL;
                    nx_addr  = PHYS_W'(req_addr);
                    nx_rdata = req_write ? '0 : iptr;
                end
                LOC_IDAT: begin
                    nx_tgt  = TGT_GPR;
                    nx_addr = gpr_phys;
                    nx_wr   = req_write;
                end
                LOC_DPL: begin
                    nx_tgt   = TGT_LOCAL;
                    nx_addr  = PHYS_W'(req_addr);
                    nx_rdata = req_write ? '0 : dptr[DATA_W-1:0];
                end
                LOC_DPH: begin
                    nx_tgt   = TGT_LOCAL;
                    nx_addr  = PHYS_W'(req_addr);
                    nx_rdata = req_write ? '0 : dptr[DPTR_W-1:DATA_W];
                end
                LOC_DDAT: begin
                    if (dram_ok) begin
                        nx_tgt  = TGT_DRAM;
                        nx_addr = dram_phys;
                        nx_wr   = req_write;
                    end else begin
                        nx_tgt  = TGT_RSVD;
                        nx_oor  = 1'b1;
                    end
                end
                default: begin
                    nx_tgt = TGT_RSVD;
                end
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Response state machine
    // ---------------------------------------------------------------
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = req_valid ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_target   <= TGT_NONE;
            out_addr     <= '0;
            out_write    <= 1'b0;
            out_wdata    <= '0;
            out_rdata    <= '0;
            out_reserved <= 1'b0;
            out_oor      <= 1'b0;
        end else if (req_valid) begin
            out_target   <= nx_tgt;
            out_addr     <= nx_addr;
            out_write    <= nx_wr;
            out_wdata    <= req_wdata;
            out_rdata    <= nx_rdata;
            out_reserved <= (nx_tgt == TGT_RSVD);
            out_oor      <= nx_oor;
        end else begin
            out_target   <= TGT_NONE;
            out_addr     <= '0;
            out_write    <= 1'b0;
            out_wdata    <= '0;
            out_rdata    <= '0;
            out_reserved <= 1'b0;
            out_oor      <= 1'b0;
        end
    end

    assign out_valid = (state == ST_RESP);

endmodule

// File: rtl/mbm_checker.sv
module mbm_checker
    import mbm_pkg::*;
#(
    parameter int PHYS_W   = 12,
    parameter int SFR_SPAN = 96,
    parameter int GPR_SPAN = 128,
    parameter int DPTR_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [DIR_AW-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              out_valid,
    input logic [2:0]        out_target,
    input logic [PHYS_W-1:0] out_addr,
    input logic              out_write,
    input logic [DATA_W-1:0] out_rdata,
    input logic              out_reserved,
    input logic              out_oor,
    input logic [DPTR_W-1:0] dptr
);

    // R10
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R10
    idle_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && out_target == 3'(TGT_NONE)));

    // R3
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_reserved |-> (!out_write && out_rdata == '0));

    // R8
    oor_is_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_oor |-> (out_reserved && !out_write));

    // R7
    dptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == LOC_DDAT) |=> dptr == DPTR_W'($past(dptr) + 1'b1));

    // R11
    dptr_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == LOC_DPL) |=> dptr[DATA_W-1:0] == $past(req_wdata));

    // R4
    gpr_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_target == 3'(TGT_GPR)) |-> (out_addr < PHYS_W'(GPR_SPAN)));

    // R2
    sfr_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_target == 3'(TGT_SFR)) |-> (out_addr < PHYS_W'(SFR_SPAN)));

endmodule

bind mem_bank_mapper mbm_checker #(
    .PHYS_W   (PHYS_W),
    .SFR_SPAN (N_PAGES * PAGE_BYTES),
    .GPR_SPAN (GPR_BLOCKS * BLOCK_BYTES),
    .DPTR_W   (DPTR_W)
) u_mbm_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .out_valid    (out_valid),
    .out_target   (out_target),
    .out_addr     (out_addr),
    .out_write    (out_write),
    .out_rdata    (out_rdata),
    .out_reserved (out_reserved),
    .out_oor      (out_oor),
    .dptr         (dptr)
);

// File: tb/test_mem_bank_mapper.sv
module test_mem_bank_mapper;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        out_valid;
    logic [2:0]  out_target;
    logic [11:0] out_addr;
    logic        out_write;
    logic [7:0]  out_wdata;
    logic [7:0]  out_rdata;
    logic        out_reserved;
    logic        out_oor;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    mem_bank_mapper i_mem_bank_mapper (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .out_valid    (out_valid),
        .out_target   (out_target),
        .out_addr     (out_addr),
        .out_write    (out_write),
        .out_wdata    (out_wdata),
        .out_rdata    (out_rdata),
        .out_reserved (out_reserved),
        .out_oor      (out_oor)
    );

    // Vector: {req[43:40], w[39], addr[38:33], wdata[32:25], tgt[24:22],
    //          eaddr[21:10], erdata[9:2], ewr[1], eoor[0]}
    function automatic logic [43:0] V(input int r, input bit w, input logic [5:0] a,
                                      input logic [7:0] d, input int t,
                                      input logic [11:0] ea, input logic [7:0] er,
                                      input bit ew, input bit eo);
        return {4'(r), w, a, d, 3'(t), ea, er, ew, eo};
    endfunction

    localparam int NV = 40;
    localparam logic [43:0] VEC [NV] = '{
        V(1,  0, 6'h10, 8'h00, 4, 12'h010, 8'h00, 0, 0), // R1 page select zero
        V(1,  0, 6'h11, 8'h00, 4, 12'h011, 8'h00, 0, 0), // R1 block select zero
        V(1,  0, 6'h12, 8'h00, 4, 12'h012, 8'h00, 0, 0), // R1 iptr zero
        V(1,  0, 6'h14, 8'h00, 4, 12'h014, 8'h00, 0, 0), // R1 dptr zero
        V(2,  0, 6'h05, 8'h00, 1, 12'h005, 8'h00, 0, 0), // R2 page 0
        V(11, 1, 6'h10, 8'h02, 4, 12'h010, 8'h00, 0, 0), // R11 page 2
        V(6,  0, 6'h10, 8'h00, 4, 12'h010, 8'h02, 0, 0), // R6
        V(2,  0, 6'h07, 8'h00, 1, 12'h027, 8'h00, 0, 0), // R2 last of page 2
        V(3,  1, 6'h08, 8'h55, 5, 12'h000, 8'h00, 0, 0), // R3 past fill 8
        V(11, 1, 6'h10, 8'h05, 4, 12'h010, 8'h00, 0, 0), // R11 page 5
        V(2,  1, 6'h05, 8'hAA, 1, 12'h055, 8'h00, 1, 0), // R2 write passes
        V(3,  0, 6'h06, 8'h00, 5, 12'h000, 8'h00, 0, 0), // R3 page 5 fill 6
        V(11, 1, 6'h10, 8'h06, 4, 12'h010, 8'h00, 0, 0), // R11 page 6
        V(3,  0, 6'h00, 8'h00, 5, 12'h000, 8'h00, 0, 0), // R3 page above 5
        V(3,  1, 6'h0F, 8'h12, 5, 12'h000, 8'h00, 0, 0), // R3 write dropped
        V(6,  0, 6'h10, 8'h00, 4, 12'h010, 8'h06, 0, 0), // R6
        V(11, 1, 6'h10, 8'h04, 4, 12'h010, 8'h00, 0, 0), // R11 page 4
        V(2,  0, 6'h03, 8'h00, 1, 12'h043, 8'h00, 0, 0), // R2 page 4 fill 4
        V(3,  0, 6'h04, 8'h00, 5, 12'h000, 8'h00, 0, 0), // R3
        V(11, 1, 6'h11, 8'h07, 4, 12'h011, 8'h00, 0, 0), // R11 bsel <- 3
        V(6,  0, 6'h11, 8'h00, 4, 12'h011, 8'h03, 0, 0), // R6 zero-extended
        V(4,  0, 6'h25, 8'h00, 2, 12'h065, 8'h00, 0, 0), // R4
        V(4,  1, 6'h3F, 8'h11, 2, 12'h07F, 8'h00, 1, 0), // R4 top byte
        V(11, 1, 6'h12, 8'h2A, 4, 12'h012, 8'h00, 0, 0), // R11 iptr
        V(5,  0, 6'h13, 8'h00, 2, 12'h02A, 8'h00, 0, 0), // R5 ignores bsel
        V(11, 1, 6'h12, 8'hC3, 4, 12'h012, 8'h00, 0, 0), // R11 iptr
        V(5,  1, 6'h13, 8'h44, 2, 12'h043, 8'h00, 1, 0), // R5 bit 7 ignored
        V(6,  0, 6'h12, 8'h00, 4, 12'h012, 8'hC3, 0, 0), // R6
        V(9,  0, 6'h18, 8'h00, 5, 12'h000, 8'h00, 0, 0), // R9
        V(9,  1, 6'h1F, 8'h01, 5, 12'h000, 8'h00, 0, 0), // R9
        V(11, 1, 6'h14, 8'hFE, 4, 12'h014, 8'h00, 0, 0), // R11 ptr lo
        V(11, 1, 6'h15, 8'h0F, 4, 12'h015, 8'h00, 0, 0), // R11 ptr hi
        V(7,  0, 6'h16, 8'h00, 3, 12'hFFE, 8'h00, 0, 0), // R7
        V(7,  1, 6'h16, 8'h33, 3, 12'hFFF, 8'h00, 1, 0), // R7 last byte
        V(8,  0, 6'h16, 8'h00, 5, 12'h000, 8'h00, 0, 1), // R8 at 4096
        V(8,  1, 6'h16, 8'h77, 5, 12'h000, 8'h00, 0, 1), // R8 no write
        V(7,  0, 6'h14, 8'h00, 4, 12'h014, 8'h02, 0, 0), // R7 ptr now 0x1002
        V(7,  0, 6'h15, 8'h00, 4, 12'h015, 8'h10, 0, 0), // R7
        V(4,  1, 6'h11, 8'h00, 4, 12'h011, 8'h00, 0, 0), // R4 bsel <- 0
        V(4,  0, 6'h20, 8'h00, 2, 12'h000, 8'h00, 0, 0)  // R4 block 0
    };

    task automatic chk(input int r, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    // one request, result sampled at the falling edge after the capturing edge
    task automatic access(input bit w, input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_write = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_res(input int r, input int t, input logic [11:0] ea,
                              input logic [7:0] er, input bit ew, input bit eo);
        chk(r, "valid",    32'(out_valid), 32'd1);
        chk(r, "target",   32'(out_target), 32'(t));
        chk(r, "addr",     32'(out_addr), 32'(ea));
        chk(r, "rdata",    32'(out_rdata), 32'(er));
        chk(r, "write",    32'(out_write), 32'(ew));
        chk(r, "oor",      32'(out_oor), 32'(eo));
        chk(r, "reserved", 32'(out_reserved), 32'(t == 5));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R10: nothing presented after reset
        chk(1, "reset valid",  32'(out_valid), 32'd0);
        chk(1, "reset target", 32'(out_target), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            v = VEC[i];
            access(v[39], v[38:33], v[32:25]);
            expect_res(int'(v[43:40]), int'(v[24:22]), v[21:10], v[9:2], v[1], v[0]);
            if (v[39]) chk(int'(v[43:40]), "wdata", 32'(out_wdata), 32'(v[32:25]));
        end

        // R10: idle cycle after the last request
        @(negedge clk);
        chk(10, "idle valid",  32'(out_valid), 32'd0);
        chk(10, "idle target", 32'(out_target), 32'd0);

        // R11: back-to-back select write then block access
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'h11; req_wdata = 8'h02;
        @(posedge clk);
        #1;
        req_write = 1'b0; req_addr = 6'h21; req_wdata = 8'h00;
        @(negedge clk);
        chk(11, "b2b first valid",  32'(out_valid), 32'd1);
        chk(11, "b2b first target", 32'(out_target), 32'd4);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        @(negedge clk);
        expect_res(11, 2, 12'h041, 8'h00, 0, 0);

        // R7 / R8: pointer wraps from 0xFFFF to zero
        access(1, 6'h14, 8'hFF);
        access(1, 6'h15, 8'hFF);
        access(0, 6'h16, 8'h00);
        expect_res(8, 5, 12'h000, 8'h00, 0, 1);
        access(0, 6'h14, 8'h00);
        expect_res(7, 4, 12'h014, 8'h00, 0, 0);
        access(0, 6'h15, 8'h00);
        expect_res(7, 4, 12'h015, 8'h00, 0, 0);
        access(0, 6'h16, 8'h00);
        expect_res(7, 3, 12'h000, 8'h00, 0, 0);

        // R1: reset in mid-run clears all select registers
        access(1, 6'h10, 8'h03);
        access(1, 6'h12, 8'h7F);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(0, 6'h10, 8'h00);
        expect_res(1, 4, 12'h010, 8'h00, 0, 0);
        access(0, 6'h11, 8'h00);
        expect_res(1, 4, 12'h011, 8'h00, 0, 0);
        access(0, 6'h12, 8'h00);
        expect_res(1, 4, 12'h012, 8'h00, 0, 0);
        access(0, 6'h14, 8'h00);
        expect_res(1, 4, 12'h014, 8'h00, 0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule